// File: doc/BRIEF.md
# Sliding-Window Calorimeter Jet Finder

The block receives a calorimeter tower grid one pseudorapidity (eta) row per cycle. Every tower carries an electromagnetic and a hadronic energy, which are added. Square patches of GRP by GRP towers are folded into coarse regions as the rows stream in, so only one partially built region row and two finished region rows are ever held.

Each time a region row completes, the block evaluates a 3x3 window of regions centred on every azimuthal (phi) position of the row before it. It emits the whole row of windows at once: one strobe, the eta index of the centre row, and for every phi lane the window energy and a jet flag. The phi direction is a ring with no boundary. The eta direction is open, so regions beyond either end count as zero. A jet flag marks a centre region that is a local maximum under an asymmetric tie-break, so a flat deposit produces only one candidate. The last centre row of a frame has no successor row. It is evaluated on a timer that keeps its latency in step with every other row.

Top module: `jet_finder`

## Requirements
- R1: Tower energy is em + had. Region (k, r) is the sum of the towers in eta rows k*GRP .. k*GRP+GRP-1 and phi columns r*GRP .. r*GRP+GRP-1. Tower phi column p is element p of `em_row` and `had_row`.
- R2: In an emitted row with centre eta c, lane p of `cand_sum` holds the sum of the nine regions at eta c-1..c+1 and phi p-1..p+1.
- R3: Phi is a ring. Lane 0's window and comparisons use lane REG_PHI-1 as its lower neighbour, and lane REG_PHI-1 uses lane 0 as its upper neighbour.
- R4: Eta does not wrap. Regions at eta -1 and eta REG_ETA count as zero in both the sum and the comparisons.
- R5: `cand_jet[p]` is 1 only when the centre region C is strictly greater than the regions at (c, p+1), (c+1, p-1), (c+1, p) and (c+1, p+1), and greater than or equal to the regions at (c, p-1), (c-1, p-1), (c-1, p) and (c-1, p+1). An all-zero neighbourhood therefore gives no jet, and no two phi-adjacent lanes of a row are both flagged.
- R6: Sums are exact at full scale. With every em and had at 2^E_W-1, no region or window sum wraps.
- R7: During and after reset `cand_row_valid` and `cand_jet` are 0. Each frame yields exactly REG_ETA strobes, with `cand_eta` going 0, 1, ..., REG_ETA-1 in order. `cand_jet` is all zero whenever there is no strobe.
- R8: Suppose rows arrive on consecutive cycles and row 0 is accepted at edge A. Then the strobe for centre row c appears right after edge A + GRP*(c+2) - 1. This includes the last row, which is timed as though rows had kept arriving.
- R9: A cycle with `row_valid` low is ignored. The values on `em_row` and `had_row` in that cycle have no effect on any result.
- R10: Accepted rows are counted from reset, and every TOW_ETA accepted rows form one frame. The next frame may start on the cycle after the last row, and no energy is carried from one frame into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | A tower row is present this cycle |
| em_row | input | TOW_PHI*E_W | Electromagnetic energy per phi column |
| had_row | input | TOW_PHI*E_W | Hadronic energy per phi column |
| cand_row_valid | output | 1 | A row of window results is present |
| cand_eta | output | clog2(REG_ETA) | Eta index of the centre region row |
| cand_sum | output | REG_PHI*WIN_W | 3x3 window energy per phi lane |
| cand_jet | output | REG_PHI | Local-maximum flag per phi lane |

## Verification
The bench builds the block with a 24 by 24 tower grid, GRP of 4 and 7-bit energies, which gives a 6 by 6 region grid. With only six lanes and six rows, the phi wrap and both eta edges touch a large share of all windows. The final-row timer also fires often enough to be tested. Random frames follow one another with no idle cycle between them, so the last-row evaluation lands on the same edge that completes the next frame's first region row. Further frames interleave idle cycles that carry garbage energies.

// File: rtl/jf_pkg.sv
package jf_pkg;

    localparam int DEF_TOW_ETA = 88;
    localparam int DEF_TOW_PHI = 72;
    localparam int DEF_GRP     = 4;
    localparam int DEF_E_W     = 7;

    // Which window evaluation, if any, happens in the current cycle.
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_BODY  = 2'd1,   // centre row has a successor row in flight
        EV_FLUSH = 2'd2    // final centre row, successor forced to zero
    } eval_e;

    typedef struct packed {
        eval_e kind;
        logic  top_edge;   // centre row is eta 0
    } eval_ctl_t;

    // Width of a region sum: tower (E_W+1 bits) times GRP*GRP.
    function automatic int region_width(input int e_w, input int grp);
        return e_w + 1 + 2 * $clog2(grp);
    endfunction

    // Index on a ring of n lanes.
    function automatic int ring_idx(input int i, input int n);
        return ((i % n) + n) % n;
    endfunction

endpackage

// File: rtl/jf_region_acc.sv
module jf_region_acc #(
    parameter int TOW_PHI = 72,
    parameter int GRP     = 4,
    parameter int E_W     = 7,
    parameter int REG_W   = 12
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 row_valid,
    input  logic [TOW_PHI-1:0][E_W-1:0]          em_row,
    input  logic [TOW_PHI-1:0][E_W-1:0]          had_row,
    output logic                                 row_done,
    output logic [TOW_PHI/GRP-1:0][REG_W-1:0]    region_row
);
    localparam int REG_PHI = TOW_PHI / GRP;
    localparam int SUB_W   = (GRP > 1) ? $clog2(GRP) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(GRP - 1);

    logic [SUB_W-1:0]                sub_q;
    logic [REG_PHI-1:0][REG_W-1:0]   acc_q;
    logic [REG_PHI-1:0][REG_W-1:0]   part;

    // Sum of GRP adjacent towers of the current row for each region lane.
    always_comb begin
        part = '0;
        for (int r = 0; r < REG_PHI; r++) begin
            for (int g = 0; g < GRP; g++) begin
                part[r] = part[r] + REG_W'(em_row[r*GRP+g]) + REG_W'(had_row[r*GRP+g]);
            end
        end
    end

    assign row_done = row_valid && (sub_q == SUB_LAST);

    always_comb begin
        for (int r = 0; r < REG_PHI; r++) begin
            region_row[r] = ((sub_q == '0) ? '0 : acc_q[r]) + part[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            acc_q <= '0;
        end else if (row_valid) begin
            sub_q <= row_done ? '0 : sub_q + 1'b1;
            acc_q <= region_row;
        end
    end

endmodule

// File: rtl/jf_window.sv
module jf_window #(
    parameter int REG_PHI = 18,
    parameter int REG_W   = 12,
    parameter int WIN_W   = 16,
    parameter int LANE    = 0
) (
    input  logic [REG_PHI-1:0][REG_W-1:0] up_row,
    input  logic [REG_PHI-1:0][REG_W-1:0] mid_row,
    input  logic [REG_PHI-1:0][REG_W-1:0] dn_row,
    output logic [WIN_W-1:0]              win_sum,
    output logic                          is_peak
);
    localparam int LO = jf_pkg::ring_idx(LANE - 1, REG_PHI);
    localparam int HI = jf_pkg::ring_idx(LANE + 1, REG_PHI);

    logic [REG_W-1:0] ctr;
    logic             beats_fwd;
    logic             holds_back;

    assign ctr = mid_row[LANE];

    assign win_sum = WIN_W'(up_row[LO])  + WIN_W'(up_row[LANE])  + WIN_W'(up_row[HI])
                   + WIN_W'(mid_row[LO]) + WIN_W'(ctr)           + WIN_W'(mid_row[HI])
                   + WIN_W'(dn_row[LO])  + WIN_W'(dn_row[LANE])  + WIN_W'(dn_row[HI]);

    // Strict against the forward half, non-strict against the backward half.
    assign beats_fwd  = (ctr > mid_row[HI]) && (ctr > dn_row[LO])
                     && (ctr > dn_row[LANE]) && (ctr > dn_row[HI]);
    assign holds_back = (ctr >= mid_row[LO]) && (ctr >= up_row[LO])
                     && (ctr >= up_row[LANE]) && (ctr >= up_row[HI]);
    assign is_peak    = beats_fwd && holds_back;

endmodule

// File: rtl/jet_finder.sv
module jet_finder
    import jf_pkg::*;
#(
    parameter int TOW_ETA = DEF_TOW_ETA,
    parameter int TOW_PHI = DEF_TOW_PHI,
    parameter int GRP     = DEF_GRP,
    parameter int E_W     = DEF_E_W,
    localparam int REG_ETA = TOW_ETA / GRP,
    localparam int REG_PHI = TOW_PHI / GRP,
    localparam int REG_W   = region_width(E_W, GRP),
    localparam int WIN_W   = REG_W + 4,
    localparam int ETA_W   = (REG_ETA > 1) ? $clog2(REG_ETA) : 1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                row_valid,
    input  logic [TOW_PHI-1:0][E_W-1:0]         em_row,
    input  logic [TOW_PHI-1:0][E_W-1:0]         had_row,
    output logic                                cand_row_valid,
    output logic [ETA_W-1:0]                    cand_eta,
    output logic [REG_PHI-1:0][WIN_W-1:0]       cand_sum,
    output logic [REG_PHI-1:0]                  cand_jet
);
    localparam int FL_W = $clog2(GRP + 1);
    localparam logic [ETA_W-1:0] LAST_ETA = ETA_W'(REG_ETA - 1);
    localparam logic [FL_W-1:0]  FL_LOAD  = FL_W'(GRP);
    localparam logic [FL_W-1:0]  FL_FIRE  = FL_W'(1);

    logic                           row_done;
    logic [REG_PHI-1:0][REG_W-1:0]  new_row;
    logic [REG_PHI-1:0][REG_W-1:0]  older_q, newer_q;
    logic [ETA_W-1:0]               next_reg_q;
    logic [FL_W-1:0]                flush_q;

    eval_ctl_t                      ctl;
    logic [ETA_W-1:0]               centre_eta;
    logic [REG_PHI-1:0][REG_W-1:0]  up_sel, mid_sel, dn_sel;
    logic [REG_PHI-1:0][WIN_W-1:0]  win_sum;
    logic [REG_PHI-1:0]             peak;

    jf_region_acc #(
        .TOW_PHI (TOW_PHI),
        .GRP     (GRP),
        .E_W     (E_W),
        .REG_W   (REG_W)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .row_valid  (row_valid),
        .em_row     (em_row),
        .had_row    (had_row),
        .row_done   (row_done),
        .region_row (new_row)
    );

    // Pick the evaluation for this cycle. A body evaluation uses the row
    // completing right now as the lower neighbour; the flush evaluation
    // reuses the stored pair with a zero lower neighbour.
    always_comb begin
        ctl.kind     = EV_IDLE;
        ctl.top_edge = 1'b0;
        centre_eta   = '0;
        if (flush_q == FL_FIRE) begin
            ctl.kind   = EV_FLUSH;
            centre_eta = LAST_ETA;
        end else if (row_done && next_reg_q != '0) begin
            ctl.kind     = EV_BODY;
            ctl.top_edge = (next_reg_q == ETA_W'(1));
            centre_eta   = next_reg_q - 1'b1;
        end
    end

    always_comb begin
        up_sel  = ctl.top_edge ? '0 : older_q;
        mid_sel = newer_q;
        dn_sel  = (ctl.kind == EV_FLUSH) ? '0 : new_row;
    end

    for (genvar p = 0; p < REG_PHI; p++) begin : g_lane
        jf_window #(
            .REG_PHI (REG_PHI),
            .REG_W   (REG_W),
            .WIN_W   (WIN_W),
            .LANE    (p)
        ) u_win (
            .up_row  (up_sel),
            .mid_row (mid_sel),
            .dn_row  (dn_sel),
            .win_sum (win_sum[p]),
            .is_peak (peak[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q    <= '0;
            newer_q    <= '0;
            next_reg_q <= '0;
            flush_q    <= '0;
        end else begin
            if (row_done) begin
                older_q    <= newer_q;
                newer_q    <= new_row;
                next_reg_q <= (next_reg_q == LAST_ETA) ? '0 : next_reg_q + 1'b1;
            end
            if (row_done && next_reg_q == LAST_ETA) begin
                flush_q <= FL_LOAD;
            end else if (flush_q != '0) begin
                flush_q <= flush_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_row_valid <= 1'b0;
            cand_eta       <= '0;
            cand_sum       <= '0;
            cand_jet       <= '0;
        end else begin
            cand_row_valid <= (ctl.kind != EV_IDLE);
            cand_jet       <= (ctl.kind != EV_IDLE) ? peak : '0;
            if (ctl.kind != EV_IDLE) begin
                cand_eta <= centre_eta;
                cand_sum <= win_sum;
            end
        end
    end

endmodule

// File: rtl/jf_checker.sv
module jf_checker #(
    parameter int REG_ETA = 22,
    parameter int REG_PHI = 18,
    parameter int WIN_W   = 16,
    parameter int ETA_W   = 5
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          cand_row_valid,
    input logic [ETA_W-1:0]              cand_eta,
    input logic [REG_PHI-1:0][WIN_W-1:0] cand_sum,
    input logic [REG_PHI-1:0]            cand_jet
);
    localparam logic [ETA_W-1:0] LAST_ETA = ETA_W'(REG_ETA - 1);

    logic [ETA_W-1:0] want_eta_q;
    logic             twin;

    always_ff @(posedge clk) begin
        if (rst) begin
            want_eta_q <= '0;
        end else if (cand_row_valid) begin
            want_eta_q <= (cand_eta == LAST_ETA) ? '0 : cand_eta + 1'b1;
        end
    end

    always_comb begin
        twin = 1'b0;
        for (int p = 0; p < REG_PHI; p++) begin
            if (cand_jet[p] && cand_jet[(p + 1) % REG_PHI]) twin = 1'b1;
        end
    end

    AST_ETA_IN_GRID: assert property (@(posedge clk) disable iff (rst)
        cand_row_valid |-> cand_eta <= LAST_ETA);  // R7

    AST_ETA_ORDER: assert property (@(posedge clk) disable iff (rst)
        cand_row_valid |-> cand_eta == want_eta_q);  // R7

    AST_JET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !cand_row_valid |-> cand_jet == '0);  // R7

    AST_NO_TWIN_PEAK: assert property (@(posedge clk) disable iff (rst)
        cand_row_valid |-> !twin);  // R5

    for (genvar p = 0; p < REG_PHI; p++) begin : g_nz
        AST_PEAK_HAS_ENERGY: assert property (@(posedge clk) disable iff (rst)
            cand_jet[p] |-> cand_sum[p] != '0);  // R5
    end

endmodule

bind jet_finder jf_checker #(
    .REG_ETA (REG_ETA),
    .REG_PHI (REG_PHI),
    .WIN_W   (WIN_W),
    .ETA_W   (ETA_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cand_row_valid (cand_row_valid),
    .cand_eta       (cand_eta),
    .cand_sum       (cand_sum),
    .cand_jet       (cand_jet)
);

// File: tb/jet_finder_bench.sv
`timescale 1ns/1ps
module jet_finder_bench;

    localparam int TE   = 24;
    localparam int TP   = 24;
    localparam int G    = 4;
    localparam int EW   = 7;
    localparam int RE   = TE / G;
    localparam int RP   = TP / G;
    localparam int RW   = EW + 1 + 2 * $clog2(G);
    localparam int WW   = RW + 4;
    localparam int ETAW = $clog2(RE);
    localparam int EMAX = (1 << EW) - 1;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     row_valid = 1'b0;
    logic [TP-1:0][EW-1:0]    em_row = '0;
    logic [TP-1:0][EW-1:0]    had_row = '0;
    logic                     cand_row_valid;
    logic [ETAW-1:0]          cand_eta;
    logic [RP-1:0][WW-1:0]    cand_sum;
    logic [RP-1:0]            cand_jet;

    always #2 clk = ~clk;   // 250 MHz

    jet_finder #(.TOW_ETA(TE), .TOW_PHI(TP), .GRP(G), .E_W(EW)) u_jet_finder (
        .clk(clk), .rst(rst), .row_valid(row_valid), .em_row(em_row), .had_row(had_row),
        .cand_row_valid(cand_row_valid), .cand_eta(cand_eta),
        .cand_sum(cand_sum), .cand_jet(cand_jet)
    );

    typedef struct {
        int     eta;
        int     sum[RP];
        bit     jet[RP];
        longint due;
        string  tag;
    } exp_t;

    exp_t   q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    bit     done = 1'b0;
    int     fe[TE][TP];
    int     fh[TE][TP];
    int     rg[RE][RP];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rv(int e, int p);
        if (e < 0 || e >= RE) return 0;
        return rg[e][((p % RP) + RP) % RP];
    endfunction

    task automatic clear_frame();
        for (int e = 0; e < TE; e++)
            for (int p = 0; p < TP; p++) begin
                fe[e][p] = 0;
                fh[e][p] = 0;
            end
    endtask

    task automatic rand_frame(int density);
        for (int e = 0; e < TE; e++)
            for (int p = 0; p < TP; p++) begin
                fe[e][p] = ($urandom_range(99) < density) ? int'($urandom_range(EMAX)) : 0;
                fh[e][p] = ($urandom_range(99) < density) ? int'($urandom_range(EMAX)) : 0;
            end
    endtask

    // Model: regions, 3x3 ring/open windows and the tie-broken maximum.
    task automatic expect_frame(string tag, longint a0, bit timed);
        for (int k = 0; k < RE; k++)
            for (int r = 0; r < RP; r++) rg[k][r] = 0;
        for (int e = 0; e < TE; e++)
            for (int p = 0; p < TP; p++) rg[e/G][p/G] += fe[e][p] + fh[e][p];
        for (int c = 0; c < RE; c++) begin
            exp_t it;
            it.eta = c;
            it.tag = tag;
            it.due = timed ? a0 + G * (c + 2) - 1 : -1;
            for (int p = 0; p < RP; p++) begin
                int s = 0;
                int m = rv(c, p);
                for (int de = -1; de <= 1; de++)
                    for (int dp = -1; dp <= 1; dp++) s += rv(c + de, p + dp);
                it.sum[p] = s;
                it.jet[p] = (m > rv(c, p+1)) && (m > rv(c+1, p-1)) && (m > rv(c+1, p))
                         && (m > rv(c+1, p+1)) && (m >= rv(c, p-1)) && (m >= rv(c-1, p-1))
                         && (m >= rv(c-1, p)) && (m >= rv(c-1, p+1));
            end
            q.push_back(it);
        end
    endtask

    // Called at a negedge; returns at a negedge with row_valid low.
    task automatic drive_frame(string tag, int gap_pct);
        longint a0 = cyc + 1;
        expect_frame(tag, a0, gap_pct == 0);
        for (int i = 0; i < TE; i++) begin
            if (gap_pct > 0) begin
                while ($urandom_range(99) < gap_pct) begin
                    row_valid = 1'b0;
                    for (int p = 0; p < TP; p++) begin
                        em_row[p]  = EW'($urandom_range(EMAX));
                        had_row[p] = EW'($urandom_range(EMAX));
                    end
                    @(negedge clk);
                end
            end
            row_valid = 1'b1;
            for (int p = 0; p < TP; p++) begin
                em_row[p]  = EW'(fe[i][p]);
                had_row[p] = EW'(fh[i][p]);
            end
            @(negedge clk);
        end
        row_valid = 1'b0;
    endtask

    // Monitor: pop the scoreboard and compare each emitted row.
    always @(negedge clk) begin
        if (!rst && cand_row_valid && !done) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R7 unexpected strobe: got eta %0d, expected no row", cand_eta);
            end else begin
                exp_t it;
                int   bl;
                it = q.pop_front();
                bl = -1;
                for (int p = RP - 1; p >= 0; p--)
                    if (int'(cand_sum[p]) != it.sum[p] || cand_jet[p] != it.jet[p]) bl = p;
                if (int'(cand_eta) != it.eta) begin
                    n_bad++;
                    $display("FAIL R7 [%s] eta got %0d expected %0d", it.tag, cand_eta, it.eta);
                end else if (bl >= 0) begin
                    n_bad++;
                    $display("FAIL [%s] eta %0d lane %0d sum/jet got %0d/%0d expected %0d/%0d",
                             it.tag, it.eta, bl, cand_sum[bl], cand_jet[bl], it.sum[bl], it.jet[bl]);
                end else if (it.due >= 0 && cyc != it.due) begin
                    n_bad++;
                    $display("FAIL R8 [%s] eta %0d arrival cycle got %0d expected %0d",
                             it.tag, it.eta, cyc, it.due);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog expired: got no end of run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_cmp++;  // R7 reset state
        if (cand_row_valid !== 1'b0 || cand_jet !== '0) begin
            n_bad++;
            $display("FAIL R7 reset outputs got valid=%0b jet=%0h expected 0/0",
                     cand_row_valid, cand_jet);
        end
        rst = 1'b0;

        // R1 R2: isolated deposits inside the grid
        clear_frame();
        fe[10][13] = 100; fh[10][13] = 27; fe[11][14] = 5;
        drive_frame("R1 R2 single deposit", 0);

        // R3: deposits on both sides of the phi ring seam
        clear_frame();
        fe[9][0] = 90; fe[9][TP-1] = 60; fh[9][TP-1] = 10;
        drive_frame("R3 phi wrap", 0);

        // R4: deposits on the first and last eta rows
        clear_frame();
        fe[0][5] = 80; fh[TE-1][17] = 70;
        drive_frame("R4 eta edges", 0);

        // R5: equal neighbouring regions along phi and along eta
        clear_frame();
        fe[5][13] = 50; fe[5][17] = 50; fe[13][5] = 40; fh[17][5] = 40;
        drive_frame("R5 plateau tie-break", 0);

        // R6: full-scale energy everywhere
        for (int e = 0; e < TE; e++)
            for (int p = 0; p < TP; p++) begin
                fe[e][p] = EMAX;
                fh[e][p] = EMAX;
            end
        drive_frame("R6 full scale", 0);

        // R10: random frames back to back, no idle cycle between them
        for (int k = 0; k < 6; k++) begin
            rand_frame((k % 3 == 0) ? 8 : (k % 3 == 1) ? 30 : 90);
            drive_frame("R10 back-to-back random", 0);
        end

        // R9: idle cycles carrying garbage energies
        for (int k = 0; k < 2; k++) begin
            rand_frame(25);
            drive_frame("R9 gaps with garbage", 30);
        end

        repeat (3 * G + 8) @(negedge clk);
        n_cmp++;  // R7 every expected row arrived
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R7 rows still pending got %0d expected 0", q.size());
        end
        finish_run();
    end

endmodule